// File: doc/BRIEF.md
# SPI FIFO Status and Interrupt Flag Unit

This block sits between the register bus of an SPI controller and its serial engine. It holds a transmit queue and a receive queue, each 16 words deep and up to 32 bits wide. Software fills the transmit queue by writing a data port and drains the receive queue by reading another data port. The serial engine takes transmit words with a pop strobe, delivers receive words with a push strobe, and pulses an end-of-transfer line when it releases the peripheral.

Software also sees occupancy counts, a programmable receive threshold and flush strobes. Each direction has three registers: a flag register, an enable mask and a write-one-to-clear register. Each direction drives its own interrupt line, which goes high while any flag of that direction is set and enabled. Full, empty and above-threshold are level flags derived from the queue state. Peripheral-released is a sticky event flag.

Each queue is controlled by an occupancy state machine with three states: `Q_EMPTY`, `Q_PART` and `Q_FULL`. Its transitions are:
- fill-first: `Q_EMPTY`→`Q_PART`
- fill-last: `Q_PART`→`Q_FULL`
- drain-first: `Q_FULL`→`Q_PART`
- drain-last: `Q_PART`→`Q_EMPTY`
- flush: any state→`Q_EMPTY`

Each sticky flag is a two-state machine, `EV_IDLE` and `EV_PENDING`. Its transitions are:
- arm: `EV_IDLE`→`EV_PENDING`, on the end-of-transfer pulse
- acknowledge: `EV_PENDING`→`EV_IDLE`, on a clear write with no pulse in the same cycle

Top module: `sfq_flag_unit`

## Requirements
- R1: After reset both queues are empty and every count and threshold is 0. Both enable masks are 0 and both interrupts are low. The transmit flag register reads 0x2 (empty), the receive flag register reads 0, `eng_tx_empty` is 1 and `eng_rx_full` is 0.
- R2: A write to offset 0x50 appends a word to the transmit queue, and `eng_tx_data` shows the oldest word; each `eng_tx_pop` removes it. A word pushed with `eng_rx_push` appears at offset 0x90, and a read there returns the oldest receive word and removes it in the same cycle.
- R3: The read at offset 0x40 shows the receive count in bits 12:8 and the transmit count in bits 20:16. The full range from 0 to 16 is shown.
- R4: A push into a full queue is dropped, and the count and the stored words stay unchanged. A pop from an empty queue returns 0 and leaves the count at 0.
- R5: Push and pop in the same cycle are both judged on the state before that cycle. On a full queue the pop takes effect and the push is dropped, so the count becomes 15. On an empty queue the push takes effect and the pop returns 0, so the count becomes 1.
- R6: At offset 0x4C, bits 3:0 hold the receive threshold and bits 7:4 hold the transmit threshold; both read back. Writing 1 to bit 11 empties the receive queue and writing 1 to bit 12 empties the transmit queue. Both flush bits read as 0. A flush overrides a push in the same cycle.
- R7: The transmit flag register at 0x14 shows bit 0 when the queue is full and bit 1 when it is empty. Both bits follow the queue state every cycle.
- R8: Bit 5 of the receive flag register at 0x20 is set while the receive count is at least the threshold. A threshold of 0 counts as 16.
- R9: An `eng_xfer_end` pulse sets bit 6 in both flag registers. The bit stays set until a write with bit 6 set reaches that direction's clear register (0x1C for transmit, 0x28 for receive). Clearing one direction leaves the other untouched. A clear write has no effect on the level flags.
- R10: When a clear write and an `eng_xfer_end` pulse fall in the same cycle, bit 6 stays set.
- R11: `irq_tx` is high exactly when a transmit flag bit is set and the same bit is set in the enable register at 0x18. `irq_rx` follows the same rule with the enable register at 0x24. Both enable registers read back bits 6:0, and the two lines are independent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (pops the receive port) |
| reg_addr | input | ADDR_W | Byte offset |
| reg_wdata | input | REG_W | Write data |
| reg_rdata | output | REG_W | Read data, valid in the cycle of the read |
| eng_tx_pop | input | 1 | Engine takes the oldest transmit word |
| eng_tx_data | output | WIDTH | Oldest transmit word, 0 when empty |
| eng_tx_empty | output | 1 | Transmit queue empty |
| eng_rx_push | input | 1 | Engine delivers a receive word |
| eng_rx_data | input | WIDTH | Receive word |
| eng_rx_full | output | 1 | Receive queue full |
| eng_xfer_end | input | 1 | End-of-transfer pulse |
| irq_rx | output | 1 | Receive interrupt |
| irq_tx | output | 1 | Transmit interrupt |

## Verification
The collisions that matter are those where two functions meet in one cycle. The bench covers four of them:
- a bus push and an engine pop on a full transmit queue
- an engine push and a bus pop on an empty receive queue
- a receive flush together with an engine push
- a clear write landing on the same edge as an end-of-transfer pulse

Each is provoked by driving both strobes in one cycle. The result is then judged through the occupancy register, the sticky bit and the scoreboard, which would catch any word that should have been dropped.

// File: rtl/sfq_pkg.sv
package sfq_pkg;

    typedef enum logic [1:0] {
        Q_EMPTY,
        Q_PART,
        Q_FULL
    } q_state_e;

    typedef enum logic {
        EV_IDLE,
        EV_PENDING
    } ev_state_e;

    // Byte offsets decoded by software
    localparam int A_TX_FLAG = 'h14;
    localparam int A_TX_EN   = 'h18;
    localparam int A_TX_CLR  = 'h1C;
    localparam int A_RX_FLAG = 'h20;
    localparam int A_RX_EN   = 'h24;
    localparam int A_RX_CLR  = 'h28;
    localparam int A_STATUS  = 'h40;
    localparam int A_CFG     = 'h4C;
    localparam int A_TX_DATA = 'h50;
    localparam int A_RX_DATA = 'h90;

    // Flag bit positions
    localparam int TXB_FULL   = 0;
    localparam int TXB_EMPTY  = 1;
    localparam int RXB_ABOVE  = 5;
    localparam int B_RELEASED = 6;

    // Configuration and status field positions
    localparam int CFG_RX_THR_LSB = 0;
    localparam int CFG_TX_THR_LSB = 4;
    localparam int CFG_RX_FLUSH   = 11;
    localparam int CFG_TX_FLUSH   = 12;
    localparam int ST_RX_CNT_LSB  = 8;
    localparam int ST_TX_CNT_LSB  = 16;

endpackage

// File: rtl/sfq_fifo.sv
module sfq_fifo import sfq_pkg::*; #(
    parameter int DEPTH = 16,
    parameter int WIDTH = 32,
    localparam int PW = $clog2(DEPTH),
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [WIDTH-1:0] push_data,
    input  logic             pop,
    input  logic             flush,
    output logic [WIDTH-1:0] head,
    output logic [CW-1:0]    count,
    output logic             full,
    output logic             empty
);

    q_state_e         state_q, state_d;
    logic [WIDTH-1:0] mem [DEPTH];
    logic [PW-1:0]    wr_ptr, rd_ptr;
    logic [CW-1:0]    count_q, count_d;
    logic             do_push, do_pop;

    // Acceptance judged on the state before the edge; flush overrides both
    always_comb begin
        do_push = push && (state_q != Q_FULL)  && !flush;
        do_pop  = pop  && (state_q != Q_EMPTY) && !flush;
        if (flush) count_d = '0;
        else       count_d = count_q + CW'(do_push) - CW'(do_pop);
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            Q_EMPTY: begin
                if (do_push) state_d = Q_PART;             // fill-first
            end
            Q_PART: begin
                if (flush)
                    state_d = Q_EMPTY;                      // flush
                else if (do_push && !do_pop && count_q == CW'(DEPTH - 1))
                    state_d = Q_FULL;                       // fill-last
                else if (do_pop && !do_push && count_q == CW'(1))
                    state_d = Q_EMPTY;                      // drain-last
            end
            Q_FULL: begin
                if (flush)       state_d = Q_EMPTY;         // flush
                else if (do_pop) state_d = Q_PART;          // drain-first
            end
            default: state_d = Q_EMPTY;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= Q_EMPTY;
        else        state_q <= state_d;
    end

    // Pointers and count
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr  <= '0;
            rd_ptr  <= '0;
            count_q <= '0;
        end else begin
            count_q <= count_d;
            if (flush) begin
                wr_ptr <= '0;
                rd_ptr <= '0;
            end else begin
                if (do_push) wr_ptr <= (wr_ptr == PW'(DEPTH - 1)) ? '0 : wr_ptr + PW'(1);
                if (do_pop)  rd_ptr <= (rd_ptr == PW'(DEPTH - 1)) ? '0 : rd_ptr + PW'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= push_data;
    end

    // Outputs
    always_comb begin
        full  = (state_q == Q_FULL);
        empty = (state_q == Q_EMPTY);
        count = count_q;
        head  = (state_q == Q_EMPTY) ? '0 : mem[rd_ptr];
    end

    assert_state_matches_count_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ((count_q == '0) == (state_q == Q_EMPTY)) &&
        ((count_q == CW'(DEPTH)) == (state_q == Q_FULL)))
        else $error("occupancy state and count disagree");

    assert_push_full_dropped_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (push && full && !pop && !flush) |=> (full && $stable(count)))
        else $error("push into full queue changed it");

    assert_pop_empty_harmless_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && empty && !push) |=> (empty && count == '0))
        else $error("pop from empty queue changed it");

    assert_flush_empties_R6: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (empty && count == '0))
        else $error("flush did not empty the queue");

endmodule

// File: rtl/sfq_event.sv
module sfq_event import sfq_pkg::*; (
    input  logic clk,
    input  logic rst_n,
    input  logic set,
    input  logic clr,
    output logic pending
);

    ev_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            EV_IDLE:    if (set)         state_d = EV_PENDING;   // arm
            EV_PENDING: if (clr && !set) state_d = EV_IDLE;      // acknowledge
            default:                     state_d = EV_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= EV_IDLE;
        else        state_q <= state_d;
    end

    always_comb pending = (state_q == EV_PENDING);

    assert_set_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
        set |=> pending)
        else $error("event lost despite set");

    assert_clear_acks_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && !set) |=> !pending)
        else $error("clear did not acknowledge event");

endmodule

// File: rtl/sfq_irq_bank.sv
module sfq_irq_bank #(
    parameter int NB   = 7,
    parameter int SBIT = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [NB-1:0] level_vec,
    input  logic          sticky,
    input  logic          en_we,
    input  logic [NB-1:0] en_wdata,
    output logic [NB-1:0] flags,
    output logic [NB-1:0] en,
    output logic          irq
);

    logic [NB-1:0] en_q;
    logic [NB-1:0] sticky_vec;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     en_q <= '0;
        else if (en_we) en_q <= en_wdata;
    end

    always_comb begin
        sticky_vec       = '0;
        sticky_vec[SBIT] = sticky;
        flags            = level_vec | sticky_vec;
        en               = en_q;
        irq              = |(flags & en_q);
    end

    assert_sticky_enabled_irq_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (sticky && en_q[SBIT]) |-> irq)
        else $error("enabled sticky flag without interrupt");

    assert_quiet_irq_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (en_q == '0) |-> !irq)
        else $error("interrupt with empty mask");

endmodule

// File: rtl/sfq_flag_unit.sv
module sfq_flag_unit import sfq_pkg::*; #(
    parameter int DEPTH  = 16,
    parameter int WIDTH  = 32,
    parameter int REG_W  = 32,
    parameter int ADDR_W = 8,
    parameter int THR_W  = 4,
    parameter int NFLAG  = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [REG_W-1:0]  reg_wdata,
    output logic [REG_W-1:0]  reg_rdata,
    input  logic              eng_tx_pop,
    output logic [WIDTH-1:0]  eng_tx_data,
    output logic              eng_tx_empty,
    input  logic              eng_rx_push,
    input  logic [WIDTH-1:0]  eng_rx_data,
    output logic              eng_rx_full,
    input  logic              eng_xfer_end,
    output logic              irq_rx,
    output logic              irq_tx
);

    localparam int CW = $clog2(DEPTH + 1);

    // Bus decode
    logic cfg_we, tx_en_we, rx_en_we, tx_clr, rx_clr;
    logic tx_push, rx_pop, tx_flush, rx_flush;

    always_comb begin
        cfg_we   = reg_wr && (reg_addr == ADDR_W'(A_CFG));
        tx_en_we = reg_wr && (reg_addr == ADDR_W'(A_TX_EN));
        rx_en_we = reg_wr && (reg_addr == ADDR_W'(A_RX_EN));
        tx_clr   = reg_wr && (reg_addr == ADDR_W'(A_TX_CLR)) && reg_wdata[B_RELEASED];
        rx_clr   = reg_wr && (reg_addr == ADDR_W'(A_RX_CLR)) && reg_wdata[B_RELEASED];
        tx_push  = reg_wr && (reg_addr == ADDR_W'(A_TX_DATA));
        rx_pop   = reg_rd && (reg_addr == ADDR_W'(A_RX_DATA));
        tx_flush = cfg_we && reg_wdata[CFG_TX_FLUSH];
        rx_flush = cfg_we && reg_wdata[CFG_RX_FLUSH];
    end

    // Thresholds
    logic [THR_W-1:0] rx_thr_q, tx_thr_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rx_thr_q <= '0;
            tx_thr_q <= '0;
        end else if (cfg_we) begin
            rx_thr_q <= reg_wdata[CFG_RX_THR_LSB +: THR_W];
            tx_thr_q <= reg_wdata[CFG_TX_THR_LSB +: THR_W];
        end
    end

    // Queues
    logic [WIDTH-1:0] rx_head;
    logic [CW-1:0]    tx_count, rx_count;
    logic             tx_full, tx_empty, rx_full, rx_empty;

    sfq_fifo #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_tx_q (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (tx_push),
        .push_data (reg_wdata[WIDTH-1:0]),
        .pop       (eng_tx_pop),
        .flush     (tx_flush),
        .head      (eng_tx_data),
        .count     (tx_count),
        .full      (tx_full),
        .empty     (tx_empty)
    );

    sfq_fifo #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_rx_q (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (eng_rx_push),
        .push_data (eng_rx_data),
        .pop       (rx_pop),
        .flush     (rx_flush),
        .head      (rx_head),
        .count     (rx_count),
        .full      (rx_full),
        .empty     (rx_empty)
    );

    // Receive threshold compare, 0 meaning a full queue
    logic [CW-1:0] rx_thr_eff;
    logic          rx_above;

    always_comb begin
        rx_thr_eff = (rx_thr_q == '0) ? CW'(DEPTH) : CW'(rx_thr_q);
        rx_above   = (rx_count >= rx_thr_eff);
    end

    // Sticky release events
    logic tx_rel, rx_rel;

    sfq_event u_tx_rel (
        .clk     (clk),
        .rst_n   (rst_n),
        .set     (eng_xfer_end),
        .clr     (tx_clr),
        .pending (tx_rel)
    );

    sfq_event u_rx_rel (
        .clk     (clk),
        .rst_n   (rst_n),
        .set     (eng_xfer_end),
        .clr     (rx_clr),
        .pending (rx_rel)
    );

    // Level flags and interrupt banks
    logic [NFLAG-1:0] tx_level, rx_level, tx_flags, rx_flags, tx_en, rx_en;

    always_comb begin
        tx_level            = '0;
        tx_level[TXB_FULL]  = tx_full;
        tx_level[TXB_EMPTY] = tx_empty;
        rx_level            = '0;
        rx_level[RXB_ABOVE] = rx_above;
    end

    sfq_irq_bank #(.NB(NFLAG), .SBIT(B_RELEASED)) u_tx_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .level_vec (tx_level),
        .sticky    (tx_rel),
        .en_we     (tx_en_we),
        .en_wdata  (reg_wdata[NFLAG-1:0]),
        .flags     (tx_flags),
        .en        (tx_en),
        .irq       (irq_tx)
    );

    sfq_irq_bank #(.NB(NFLAG), .SBIT(B_RELEASED)) u_rx_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .level_vec (rx_level),
        .sticky    (rx_rel),
        .en_we     (rx_en_we),
        .en_wdata  (reg_wdata[NFLAG-1:0]),
        .flags     (rx_flags),
        .en        (rx_en),
        .irq       (irq_rx)
    );

    // Engine-side status
    always_comb begin
        eng_tx_empty = tx_empty;
        eng_rx_full  = rx_full;
    end

    // Read mux
    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            ADDR_W'(A_TX_FLAG): reg_rdata[NFLAG-1:0] = tx_flags;
            ADDR_W'(A_TX_EN):   reg_rdata[NFLAG-1:0] = tx_en;
            ADDR_W'(A_RX_FLAG): reg_rdata[NFLAG-1:0] = rx_flags;
            ADDR_W'(A_RX_EN):   reg_rdata[NFLAG-1:0] = rx_en;
            ADDR_W'(A_STATUS): begin
                reg_rdata[ST_RX_CNT_LSB +: CW] = rx_count;
                reg_rdata[ST_TX_CNT_LSB +: CW] = tx_count;
            end
            ADDR_W'(A_CFG): begin
                reg_rdata[CFG_RX_THR_LSB +: THR_W] = rx_thr_q;
                reg_rdata[CFG_TX_THR_LSB +: THR_W] = tx_thr_q;
            end
            ADDR_W'(A_RX_DATA): reg_rdata[WIDTH-1:0] = rx_head;
            default:            reg_rdata = '0;
        endcase
    end

    assert_release_raises_irq_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_xfer_end && tx_en[B_RELEASED] && !tx_en_we) |=> irq_tx)
        else $error("release event did not raise transmit interrupt");

    assert_flush_clears_above_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rx_flush |=> !rx_flags[RXB_ABOVE])
        else $error("above-threshold flag survived a flush");

    assert_full_empty_exclusive_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(tx_flags[TXB_FULL] && tx_flags[TXB_EMPTY]))
        else $error("transmit full and empty together");

endmodule

// File: tb/sfq_flag_unit_tb.sv
module sfq_flag_unit_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0, reg_rd = 1'b0;
    logic [7:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        eng_tx_pop = 1'b0;
    logic [31:0] eng_tx_data;
    logic        eng_tx_empty;
    logic        eng_rx_push = 1'b0;
    logic [31:0] eng_rx_data = '0;
    logic        eng_rx_full;
    logic        eng_xfer_end = 1'b0;
    logic        irq_rx, irq_tx;

    int n_cmp = 0;
    int n_bad = 0;
    logic [31:0] txq[$];
    logic [31:0] rxq[$];
    logic [31:0] mon_exp;
    logic [31:0] rv;

    always #5 clk = ~clk;

    sfq_flag_unit dut_i (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .eng_tx_pop(eng_tx_pop), .eng_tx_data(eng_tx_data), .eng_tx_empty(eng_tx_empty),
        .eng_rx_push(eng_rx_push), .eng_rx_data(eng_rx_data), .eng_rx_full(eng_rx_full),
        .eng_xfer_end(eng_xfer_end), .irq_rx(irq_rx), .irq_tx(irq_tx)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Monitor: pops the scoreboard whenever a word leaves a queue
    always begin
        @(negedge clk);
        #2;
        if (rst_n && eng_tx_pop) begin
            mon_exp = (txq.size() > 0) ? txq.pop_front() : 32'h0;
            check("R2 tx order / R4 empty pop", eng_tx_data, mon_exp);
        end
        if (rst_n && reg_rd && reg_addr == 8'h90) begin
            mon_exp = (rxq.size() > 0) ? rxq.pop_front() : 32'h0;
            check("R2 rx order / R4 empty pop", reg_rdata, mon_exp);
        end
    end

    // Drivers: each starts and ends on a falling edge
    task automatic bus_wr(input logic [7:0] a, input logic [31:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic bus_rd(input logic [7:0] a, output logic [31:0] d);
        reg_rd = 1'b1; reg_addr = a;
        #1 d = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic tx_write(input logic [31:0] d);
        bit acc;
        acc = txq.size() < 16;
        bus_wr(8'h50, d);
        if (acc) txq.push_back(d);
    endtask

    task automatic eng_pop();
        eng_tx_pop = 1'b1;
        @(negedge clk);
        eng_tx_pop = 1'b0;
    endtask

    task automatic eng_push(input logic [31:0] d);
        bit acc;
        acc = rxq.size() < 16;
        eng_rx_push = 1'b1; eng_rx_data = d;
        @(negedge clk);
        eng_rx_push = 1'b0;
        if (acc) rxq.push_back(d);
    endtask

    task automatic rx_read();
        logic [31:0] d;
        bus_rd(8'h90, d);
    endtask

    task automatic pulse_end();
        eng_xfer_end = 1'b1;
        @(negedge clk);
        eng_xfer_end = 1'b0;
    endtask

    initial begin
        #2_000_000;
        n_cmp++; n_bad++;
        $display("FAIL watchdog: actual hung expected done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        bus_rd(8'h40, rv); check("R1 status", rv, 32'h0);
        bus_rd(8'h14, rv); check("R1 tx flags", rv, 32'h2);
        bus_rd(8'h20, rv); check("R1 rx flags", rv, 32'h0);
        bus_rd(8'h4C, rv); check("R1 cfg", rv, 32'h0);
        check("R1 irqs", {30'h0, irq_rx, irq_tx}, 32'h0);
        check("R1 engine status", {30'h0, eng_tx_empty, eng_rx_full}, 32'h2);

        // R2, R3 basic transmit path
        tx_write(32'hA1A1_0001); tx_write(32'hB2B2_0002); tx_write(32'hC3C3_0003);
        bus_rd(8'h40, rv); check("R3 tx count 3", rv, 32'h0003_0000);
        repeat (3) eng_pop();

        // R4, R7 fill past full
        for (int i = 0; i < 17; i++) tx_write(32'h1000_0000 + i);
        bus_rd(8'h40, rv); check("R3 R4 tx count 16", rv, 32'h0010_0000);
        bus_rd(8'h14, rv); check("R7 tx full flag", rv, 32'h1);
        check("R7 engine not empty", {31'h0, eng_tx_empty}, 32'h0);

        // R5 push and pop together on a full queue
        reg_wr = 1'b1; reg_addr = 8'h50; reg_wdata = 32'hDEAD_BEEF; eng_tx_pop = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0; eng_tx_pop = 1'b0;
        bus_rd(8'h40, rv); check("R5 full push+pop count", rv, 32'h000F_0000);
        repeat (15) eng_pop();
        eng_pop();
        bus_rd(8'h40, rv); check("R4 empty pop count", rv, 32'h0);
        bus_rd(8'h14, rv); check("R7 tx empty flag", rv, 32'h2);

        // R2 receive path and R4 empty read
        for (int i = 0; i < 5; i++) eng_push(32'h5500_0000 + i);
        bus_rd(8'h40, rv); check("R3 rx count 5", rv, 32'h0000_0500);
        repeat (6) rx_read();
        bus_rd(8'h40, rv); check("R4 rx count after empty read", rv, 32'h0);

        // R5 push and pop together on an empty queue
        eng_rx_push = 1'b1; eng_rx_data = 32'h7777_1234; reg_rd = 1'b1; reg_addr = 8'h90;
        @(negedge clk);
        eng_rx_push = 1'b0; reg_rd = 1'b0;
        rxq.push_back(32'h7777_1234);
        bus_rd(8'h40, rv); check("R5 empty push+pop count", rv, 32'h0000_0100);
        rx_read();

        // R8 threshold 3
        bus_wr(8'h4C, 32'h3);
        eng_push(32'h1); eng_push(32'h2);
        bus_rd(8'h20, rv); check("R8 below threshold", rv, 32'h0);
        eng_push(32'h3);
        bus_rd(8'h20, rv); check("R8 at threshold", rv, 32'h20);

        // R6 flush overrides same-cycle push
        reg_wr = 1'b1; reg_addr = 8'h4C; reg_wdata = 32'h0000_0800; eng_rx_push = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0; eng_rx_push = 1'b0;
        rxq.delete();
        bus_rd(8'h40, rv); check("R6 flush beats push", rv, 32'h0);

        // R8 threshold 0 means 16, R4 receive full drop
        for (int i = 0; i < 15; i++) eng_push(32'h9000_0000 + i);
        bus_rd(8'h20, rv); check("R8 thr0 at 15", rv, 32'h0);
        eng_push(32'h9000_000F);
        bus_rd(8'h20, rv); check("R8 thr0 at 16", rv, 32'h20);
        check("R4 rx full out", {31'h0, eng_rx_full}, 32'h1);
        eng_push(32'hFFFF_FFFF);
        bus_rd(8'h40, rv); check("R4 rx count held", rv, 32'h0000_1000);
        repeat (16) rx_read();

        // R6 flush both, thresholds read back, flush bits read 0
        for (int i = 0; i < 4; i++) tx_write(32'h4400_0000 + i);
        eng_push(32'h1234);
        bus_wr(8'h4C, 32'h0000_1853);
        txq.delete(); rxq.delete();
        bus_rd(8'h40, rv); check("R6 both flushed", rv, 32'h0);
        bus_rd(8'h4C, rv); check("R6 cfg readback", rv, 32'h53);

        // R9 sticky release flag
        pulse_end();
        repeat (3) @(negedge clk);
        bus_rd(8'h14, rv); check("R9 tx sticky", rv, 32'h42);
        bus_rd(8'h20, rv); check("R9 rx sticky", rv, 32'h40);
        bus_wr(8'h1C, 32'h40);
        bus_rd(8'h14, rv); check("R9 tx cleared", rv, 32'h2);
        bus_rd(8'h20, rv); check("R9 rx untouched", rv, 32'h40);
        bus_wr(8'h28, 32'hFFFF_FFFF);
        bus_rd(8'h20, rv); check("R9 rx cleared", rv, 32'h0);
        bus_wr(8'h1C, 32'hFFFF_FFFF);
        bus_rd(8'h14, rv); check("R9 level survives clear", rv, 32'h2);

        // R10 set and clear in the same cycle
        eng_xfer_end = 1'b1; reg_wr = 1'b1; reg_addr = 8'h28; reg_wdata = 32'hFFFF_FFFF;
        @(negedge clk);
        eng_xfer_end = 1'b0; reg_wr = 1'b0;
        bus_rd(8'h20, rv); check("R10 set wins", rv, 32'h40);
        bus_wr(8'h28, 32'h40);
        bus_wr(8'h1C, 32'h40);

        // R11 interrupt masks
        check("R11 idle irqs", {30'h0, irq_rx, irq_tx}, 32'h0);
        bus_wr(8'h18, 32'h2);
        check("R11 tx empty irq", {30'h0, irq_rx, irq_tx}, 32'h1);
        bus_rd(8'h18, rv); check("R11 tx enable readback", rv, 32'h2);
        bus_wr(8'h18, 32'h0);
        bus_wr(8'h24, 32'h40);
        bus_rd(8'h24, rv); check("R11 rx enable readback", rv, 32'h40);
        check("R11 rx masked idle", {30'h0, irq_rx, irq_tx}, 32'h0);
        pulse_end();
        check("R11 rx release irq", {30'h0, irq_rx, irq_tx}, 32'h2);
        bus_wr(8'h28, 32'h40);
        check("R11 rx irq cleared", {30'h0, irq_rx, irq_tx}, 32'h0);
        bus_wr(8'h24, 32'h20);
        repeat (3) eng_push(32'hABCD);
        check("R11 rx threshold irq", {30'h0, irq_rx, irq_tx}, 32'h2);
        repeat (3) rx_read();

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule